// File: doc/BRIEF.md
# FM Synthesizer Host Write Port

This block sits between a host bus and the register file of a four-operator FM sound generator. The host sees four byte locations chosen by a 2-bit port address: two address ports and two data ports. A write to an address port latches the target register number and also records which of the two address ports was used. That choice is the bank bit. A later write to either data port is aimed at the latched register and bank. The block holds that data for a fixed number of FM cycles and then presents it to the register file as a single commit strobe.

All internal timing runs on FM cycles. One FM cycle is one pulse of a clock enable that the block derives from the master clock. After each commit, a busy flag stays high for a time that depends on which register range was written. The host can read busy and two timer overflow flags back as a status byte. A configuration input limits status reads to port 0.

Top module: `fm_wrport`

## Requirements
- R1: An internal clock enable pulses once every 6 master clocks. The commit strobe stays high for exactly one FM cycle (6 master clocks), and every busy period is a whole number of FM cycles.
- R2: Port address encoding: bit 0 = 0 selects an address port and bit 0 = 1 selects a data port. Bit 1 is the port index. A write to an address port (port addresses 0 and 2) latches the 8-bit register number. It also latches bank = bit 1 of the port address.
- R3: An accepted data write (port address 1 or 3) is committed with the latched register and bank, whichever data port carried it. The commit strobe rises after the 12th FM-cycle enable that follows the write, which is 67 to 72 master clocks after the write edge. It never rises in the same cycle as the write, and data, register and bank stay stable while the strobe is high.
- R4: A data write that arrives before 12 FM cycles have passed since the last address write is discarded and produces no commit.
- R5: After a commit to a register from 0x30 to 0x9E, busy is high for 83 FM cycles. After a commit to a register from 0xA0 to 0xB6, busy is high for 47 FM cycles.
- R6: After a commit to register 0x28, busy is high for 116 FM cycles. A commit to any register outside the R5 ranges and 0x28 leaves busy low.
- R7: Busy never rises at the moment of the data write. It rises in the same cycle as the commit strobe, and so well within 20 FM cycles of the write.
- R8: Status byte = {busy, 5'b0, timer B overflow, timer A overflow}. When the port-0-only input is low, a read returns status on any port. When it is high, a read returns status only at port address 0 and returns 0x00 elsewhere. With no read active, the output is 0x00.
- R9: A data write that arrives while a commit is pending, while the strobe is high, or while busy is high is dropped. It causes no commit and sets a sticky overrun output.
- R10: Reset clears the address latch, the pending data, busy, the strobe and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one master clock per access |
| host_rd | input | 1 | Host read enable |
| host_a | input | 2 | Port address: bit 0 selects address or data, bit 1 is the port index |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Status byte on read, otherwise zero |
| cfg_status_p0_only | input | 1 | High: status can be read only at port address 0 |
| tmr_a_ovf | input | 1 | Timer A overflow flag |
| tmr_b_ovf | input | 1 | Timer B overflow flag |
| commit_vld | output | 1 | One-FM-cycle strobe to the register file |
| commit_bank | output | 1 | Bank of the committed write |
| commit_reg | output | 8 | Register number of the committed write |
| commit_data | output | 8 | Committed data |
| busy | output | 1 | Busy flag |
| overrun | output | 1 | Sticky flag: a data write was dropped |

## Verification
The hardest case to reach is a second data write landing while a commit is already under way. It has to be refused, and the busy period that is running must be left untouched. The bench starts a commit to a long-busy register and waits until busy is seen high. It reads status through the allowed and the forbidden port, then issues a data write through the other data port. It then watches the strobe for the full busy window plus margin to confirm that no second commit appears and that overrun stays set. The early-data case is forced by writing data only three master clocks after the address.

// File: rtl/fm_wrport_pkg.sv
package fm_wrport_pkg;

  // Busy length in FM cycles for a committed register number.
  function automatic int busy_len(input logic [7:0] regn,
                                  input int len_long,
                                  input int len_mid,
                                  input int len_key);
    if (regn == 8'h28)
      return len_key;
    else if (regn >= 8'h30 && regn <= 8'h9E)
      return len_long;
    else if (regn >= 8'hA0 && regn <= 8'hB6)
      return len_mid;
    else
      return 0;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fm_cen_div.sv
module fm_cen_div #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic cen
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt == CW'(DIV - 1))
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign cen = (cnt == CW'(DIV - 1));

  AST_CEN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> !cen); // R1

endmodule

// File: rtl/fm_addr_latch.sv
module fm_addr_latch #(
  parameter int SETUP = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cen,
  input  logic       addr_we,
  input  logic       bank_in,
  input  logic [7:0] reg_in,
  output logic [7:0] reg_q,
  output logic       bank_q,
  output logic       settled
);
  localparam int AW = $clog2(SETUP + 1);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= '0;
      bank_q <= 1'b0;
      age    <= AW'(SETUP);
    end else if (addr_we) begin
      reg_q  <= reg_in;
      bank_q <= bank_in;
      age    <= '0;
    end else if (cen && age != AW'(SETUP)) begin
      age <= age + 1'b1;
    end
  end

  assign settled = (age == AW'(SETUP));

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_we |=> $stable(reg_q) && $stable(bank_q)); // R2
  AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> !settled); // R4

endmodule

// File: rtl/fm_commit_ctl.sv
module fm_commit_ctl
  import fm_wrport_pkg::*;
#(
  parameter int COMMIT_DLY = 12,
  parameter int BUSY_LONG  = 83,
  parameter int BUSY_MID   = 47,
  parameter int BUSY_KEY   = 116
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cen,
  input  logic       data_we,
  input  logic       settled,
  input  logic [7:0] reg_in,
  input  logic       bank_in,
  input  logic [7:0] din,
  output logic       commit_vld,
  output logic       commit_bank,
  output logic [7:0] commit_reg,
  output logic [7:0] commit_data,
  output logic       busy,
  output logic       overrun,
  output logic       accept,
  output logic       drop_engaged
);
  localparam int BMAX = max3(BUSY_LONG, BUSY_MID, BUSY_KEY);
  localparam int BW   = $clog2(BMAX + 1);
  localparam int PW   = $clog2(COMMIT_DLY + 1);

  logic          pend;
  logic [PW-1:0] pcnt;
  logic [BW-1:0] bcnt;
  logic          engaged;
  logic          pend_last;

  assign engaged      = pend | commit_vld | busy;
  assign accept       = data_we & settled & ~engaged;
  assign drop_engaged = data_we & engaged;
  assign pend_last    = pend && (pcnt == PW'(COMMIT_DLY - 1));
  assign busy         = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      pcnt        <= '0;
      bcnt        <= '0;
      commit_vld  <= 1'b0;
      commit_bank <= 1'b0;
      commit_reg  <= '0;
      commit_data <= '0;
      overrun     <= 1'b0;
    end else begin
      if (cen) begin
        commit_vld <= 1'b0;
        if (bcnt != '0)
          bcnt <= bcnt - 1'b1;
        if (pend_last) begin
          pend       <= 1'b0;
          commit_vld <= 1'b1;
          bcnt       <= BW'(busy_len(commit_reg, BUSY_LONG, BUSY_MID, BUSY_KEY));
        end else if (pend) begin
          pcnt <= pcnt + 1'b1;
        end
      end
      if (accept) begin
        pend        <= 1'b1;
        pcnt        <= '0;
        commit_reg  <= reg_in;
        commit_bank <= bank_in;
        commit_data <= din;
      end
      if (drop_engaged)
        overrun <= 1'b1;
    end
  end

  AST_COMMIT_ONE_FM: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld && cen |=> !commit_vld); // R3
  AST_COMMIT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_vld) |-> $past(pend)); // R3
  AST_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld && !cen |=> $stable(commit_data) && $stable(commit_reg) && $stable(commit_bank)); // R3
  AST_BUSY_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $rose(commit_vld)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9
  AST_NO_COMMIT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_engaged && !pend |=> !$rose(commit_vld)); // R9

endmodule

// File: rtl/fm_wrport.sv
module fm_wrport #(
  parameter int CEN_DIV    = 6,
  parameter int ADDR_SETUP = 12,
  parameter int COMMIT_DLY = 12,
  parameter int BUSY_LONG  = 83,
  parameter int BUSY_MID   = 47,
  parameter int BUSY_KEY   = 116
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_a,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  input  logic       cfg_status_p0_only,
  input  logic       tmr_a_ovf,
  input  logic       tmr_b_ovf,
  output logic       commit_vld,
  output logic       commit_bank,
  output logic [7:0] commit_reg,
  output logic [7:0] commit_data,
  output logic       busy,
  output logic       overrun
);
  logic       cen;
  logic       addr_we;
  logic       data_we;
  logic [7:0] lat_reg;
  logic       lat_bank;
  logic       settled;
  logic       accept;
  logic       drop_engaged;
  logic       status_ok;

  assign addr_we = host_wr & ~host_a[0];
  assign data_we = host_wr &  host_a[0];

  fm_cen_div #(.DIV(CEN_DIV)) u_cen (
    .clk   (clk),
    .rst_n (rst_n),
    .cen   (cen)
  );

  fm_addr_latch #(.SETUP(ADDR_SETUP)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen     (cen),
    .addr_we (addr_we),
    .bank_in (host_a[1]),
    .reg_in  (host_din),
    .reg_q   (lat_reg),
    .bank_q  (lat_bank),
    .settled (settled)
  );

  fm_commit_ctl #(
    .COMMIT_DLY (COMMIT_DLY),
    .BUSY_LONG  (BUSY_LONG),
    .BUSY_MID   (BUSY_MID),
    .BUSY_KEY   (BUSY_KEY)
  ) u_commit (
    .clk          (clk),
    .rst_n        (rst_n),
    .cen          (cen),
    .data_we      (data_we),
    .settled      (settled),
    .reg_in       (lat_reg),
    .bank_in      (lat_bank),
    .din          (host_din),
    .commit_vld   (commit_vld),
    .commit_bank  (commit_bank),
    .commit_reg   (commit_reg),
    .commit_data  (commit_data),
    .busy         (busy),
    .overrun      (overrun),
    .accept       (accept),
    .drop_engaged (drop_engaged)
  );

  assign status_ok = host_rd & (~cfg_status_p0_only | (host_a == 2'd0));
  assign host_dout = status_ok ? {busy, 5'b0, tmr_b_ovf, tmr_a_ovf} : 8'h00;

  AST_NO_ACCEPT_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !settled |=> !$rose(commit_vld)); // R4
  AST_NO_STROBE_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !commit_vld && !busy); // R7
  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && cfg_status_p0_only && host_a != 2'd0 |-> host_dout == 8'h00); // R8

endmodule

// File: tb/fm_wrport_test.sv
module fm_wrport_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_a = 2'd0;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout;
  logic       cfg_status_p0_only = 1'b0;
  logic       tmr_a_ovf = 1'b0;
  logic       tmr_b_ovf = 1'b0;
  logic       commit_vld;
  logic       commit_bank;
  logic [7:0] commit_reg;
  logic [7:0] commit_data;
  logic       busy;
  logic       overrun;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fm_wrport uut (
    .clk                (clk),
    .rst_n              (rst_n),
    .host_wr            (host_wr),
    .host_rd            (host_rd),
    .host_a             (host_a),
    .host_din           (host_din),
    .host_dout          (host_dout),
    .cfg_status_p0_only (cfg_status_p0_only),
    .tmr_a_ovf          (tmr_a_ovf),
    .tmr_b_ovf          (tmr_b_ovf),
    .commit_vld         (commit_vld),
    .commit_bank        (commit_bank),
    .commit_reg         (commit_reg),
    .commit_data        (commit_data),
    .busy               (busy),
    .overrun            (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_a = a; host_din = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_status(input logic [1:0] a, input bit p0only, output logic [7:0] v);
    @(negedge clk);
    cfg_status_p0_only = p0only; host_rd = 1'b1; host_a = a;
    #1 v = host_dout;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_len(input logic [7:0] r);
    if (r == 8'h28) return 116;
    if (r >= 8'h30 && r <= 8'h9E) return 83;
    if (r >= 8'hA0 && r <= 8'hB6) return 47;
    return 0;
  endfunction

  // Full write: address through port aport, data through dport, then verify commit and busy.
  task automatic t_write(input logic [1:0] aport, input logic [1:0] dport,
                         input logic [7:0] r, input logic [7:0] d, input string tag);
    int n; int sw; int bw; bit busy_at_rise; bit busy_early;
    host_write(aport, r);
    idle(73);
    host_write(dport, d);
    n = 1; busy_early = 0;
    while (!commit_vld && n < 100) begin
      if (busy) busy_early = 1;
      @(negedge clk); n++;
    end
    chk(n >= 67 && n <= 72, {tag, " R3 commit delay"}, n, 67);
    chk(!busy_early, {tag, " R7 busy before commit"}, int'(busy_early), 0);
    chk(commit_bank == aport[1], {tag, " R2 bank from address port"}, int'(commit_bank), int'(aport[1]));
    chk(commit_reg == r && commit_data == d, {tag, " R3 reg/data"},
        int'({commit_reg, commit_data}), int'({r, d}));
    busy_at_rise = busy;
    chk(busy_at_rise == (exp_len(r) != 0), {tag, " R7 busy rises with strobe"},
        int'(busy_at_rise), int'(exp_len(r) != 0));
    sw = 0; bw = 0;
    for (int i = 0; i < 800; i++) begin
      if (commit_vld) sw++;
      if (busy) bw++;
      @(negedge clk);
    end
    chk(sw == 6, {tag, " R1 strobe width"}, sw, 6);
    if (r == 8'h28 || exp_len(r) == 0)
      chk(bw == exp_len(r) * 6, {tag, " R6 busy length"}, bw, exp_len(r) * 6);
    else
      chk(bw == exp_len(r) * 6, {tag, " R5 busy length"}, bw, exp_len(r) * 6);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(!commit_vld && !busy && !overrun, "R10 reset outputs",
        int'({commit_vld, busy, overrun}), 0);
    read_status(2'd0, 1'b0, v);
    chk(v == 8'h00, "R10 reset status", v, 0);
    @(negedge clk);
    #1 chk(host_dout == 8'h00, "R8 no read gives zero", host_dout, 0);
  endtask

  task automatic t_early;
    int seen;
    host_write(2'd0, 8'h50);
    idle(3);
    host_write(2'd1, 8'h77);
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      if (commit_vld) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R4 early data discarded", seen, 0);
    chk(!overrun, "R4 early drop is not overrun", int'(overrun), 0);
  endtask

  task automatic t_overrun;
    logic [7:0] v; int seen; int bw;
    tmr_a_ovf = 1'b1; tmr_b_ovf = 1'b0;
    host_write(2'd2, 8'h40);
    idle(73);
    host_write(2'd3, 8'h11);
    while (!busy) @(negedge clk);
    idle(20);
    read_status(2'd2, 1'b0, v);
    chk(v == 8'h81, "R8 status any port", v, 8'h81);
    read_status(2'd3, 1'b1, v);
    chk(v == 8'h00, "R8 status blocked off port 0", v, 0);
    read_status(2'd0, 1'b1, v);
    tmr_b_ovf = 1'b1;
    chk(v == 8'h81, "R8 status port 0", v, 8'h81);
    read_status(2'd0, 1'b1, v);
    chk(v == 8'h83, "R8 timer B bit", v, 8'h83);
    host_write(2'd1, 8'h22);
    chk(overrun, "R9 overrun set", int'(overrun), 1);
    seen = 0; bw = 0;
    for (int i = 0; i < 700; i++) begin
      if (commit_vld) seen++;
      if (busy) bw++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 dropped write not committed", seen, 0);
    chk(bw > 0 && bw < 83 * 6 && !busy, "R9 busy window unchanged", bw, 83 * 6);
    chk(overrun, "R9 overrun sticky", int'(overrun), 1);
    read_status(2'd0, 1'b0, v);
    chk(v == 8'h03, "R8 busy cleared in status", v, 8'h03);
    tmr_a_ovf = 1'b0; tmr_b_ovf = 1'b0;
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_write(2'd0, 2'd3, 8'h30, 8'hA5, "bank0 via port1 data");
    t_write(2'd2, 2'd1, 8'hB6, 8'h5A, "bank1 via port0 data");
    t_write(2'd0, 2'd1, 8'h28, 8'hF1, "key register");
    t_write(2'd0, 2'd1, 8'h22, 8'h08, "no-wait register");
    t_write(2'd2, 2'd3, 8'h9E, 8'h3C, "long range top");
    t_early();
    t_overrun();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    #1 chk(!overrun && !busy && !commit_vld, "R10 reset clears overrun",
           int'({overrun, busy, commit_vld}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule